// File: doc/BRIEF.md
# Dual-Read Register File with Hard-Wired Zero Entry

This block is the small, fast working storage at the centre of a simple load/store processor. It holds thirty-two words of thirty-two bits. One port writes a word on the rising clock edge, and two separate ports read words combinationally, each from its own address. No clock is involved in a read. Entry 0 holds no storage: both read ports always return zero for it, and writes to it are discarded.

The write path is built from three parts. A one-hot select vector comes from shifting the enable bit left by the write address. Each storage word is a clock-enable register that loads only when its select bit is set. The clock itself is never gated. The contents have no reset. A read that hits the entry being written in the same cycle returns the old word until the edge completes the write, because there is no write-to-read forwarding.

Top module: `dual_port_regfile`

## Requirements
- R1: The array has 32 entries of 32 bits addressed by 5-bit indices, and each of entries 1 to 31 keeps its own independently written value.
- R2: When `wr_en` is 1 at a rising edge of `clk`, the entry at `wr_addr` takes `wr_data`, and that value is visible on a read port right after the edge.
- R3: When `wr_en` is 0 at a rising edge, no entry changes.
- R4: Address 0 reads as 32'h0 on both read ports at all times, and a write to address 0 has no effect.
- R5: A write changes only the addressed entry, and every other entry keeps its value.
- R6: Each read port outputs the entry selected by its own address combinationally, following an address change without any clock edge.
- R7: When a read address equals the write address during an enabled write, the read port shows the old contents until the rising edge, and the new contents after it.
- R8: Both read ports may select the same address at once, and each returns that entry's correct value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, writes on rising edge |
| wr_en | input | 1 | Write enable, active high |
| wr_addr | input | 5 | Entry written at the edge |
| wr_data | input | 32 | Word to write |
| rd_addr_a | input | 5 | Address for read port A |
| rd_data_a | output | 32 | Word at `rd_addr_a` |
| rd_addr_b | input | 5 | Address for read port B |
| rd_data_b | output | 32 | Word at `rd_addr_b` |

## Verification
The hardest faults to expose are a write that spills into other entries and a read port stuck on one fixed entry. With uniform data, both produce plausible-looking values. The stimulus first fills entries 1 to 31 with a distinct pattern each, so that any cross-write or wrong selection shows up as a mismatched word. It then sweeps every address on both ports, with port B running in reverse so the two ports never share a pattern. After that, a table of mixed operations re-reads the written entry and a neighbour both before and after each edge. The table includes disabled writes, writes to entry 0 and same-cycle read-of-write cases.

// File: rtl/rf_pkg.sv
`timescale 1ns/1ps
package rf_pkg;
   localparam int unsigned RF_DATA_W_DFLT = 32;
   localparam int unsigned RF_ADDR_W_DFLT = 5;
   localparam int unsigned RF_ADDR_W_MAX  = 10;
endpackage

// File: rtl/rf_wr_decode.sv
`timescale 1ns/1ps
module rf_wr_decode #(
   parameter int unsigned ADDR_W = 5,
   localparam int unsigned DEPTH = 1 << ADDR_W
) (
   input  logic              en,
   input  logic [ADDR_W-1:0] addr,
   output logic [DEPTH-1:0]  sel
);
   // enable bit shifted to the addressed slot gives a one-hot (or all-zero) select
   assign sel = {{(DEPTH-1){1'b0}}, en} << addr;
endmodule

// File: rtl/rf_word.sv
`timescale 1ns/1ps
module rf_word #(
   parameter int unsigned DATA_W    = 32,
   parameter bit          HARDWIRED = 1'b0
) (
   input  logic              clk,
   input  logic              load,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] q
);
   generate
      if (HARDWIRED) begin : g_const
         logic unused_inputs;
         assign unused_inputs = ^{clk, load, d};
         assign q = '0;
      end else begin : g_store
         logic [DATA_W-1:0] held;
         // clock-enable register: clock runs freely, load selects new data
         always_ff @(posedge clk) begin
            if (load) held <= d;
         end
         assign q = held;
      end
   endgenerate
endmodule

// File: rtl/rf_rd_mux.sv
`timescale 1ns/1ps
module rf_rd_mux #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 5,
   localparam int unsigned DEPTH = 1 << ADDR_W
) (
   input  logic [DEPTH-1:0][DATA_W-1:0] words,
   input  logic [ADDR_W-1:0]            addr,
   output logic [DATA_W-1:0]            data
);
   assign data = words[addr];
endmodule

// File: rtl/dual_port_regfile.sv
`timescale 1ns/1ps
module dual_port_regfile #(
   parameter int unsigned DATA_W = rf_pkg::RF_DATA_W_DFLT,
   parameter int unsigned ADDR_W = rf_pkg::RF_ADDR_W_DFLT
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr_a,
   output logic [DATA_W-1:0] rd_data_a,
   input  logic [ADDR_W-1:0] rd_addr_b,
   output logic [DATA_W-1:0] rd_data_b
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("dual_port_regfile: DATA_W must be at least 1");
      end
      if (ADDR_W < 1 || ADDR_W > rf_pkg::RF_ADDR_W_MAX) begin : g_bad_addr
         $error("dual_port_regfile: ADDR_W out of supported range");
      end
   endgenerate

   logic [DEPTH-1:0]             load_sel;
   logic [DEPTH-1:0][DATA_W-1:0] words;

   rf_wr_decode #(.ADDR_W(ADDR_W)) u_dec (
      .en   (wr_en),
      .addr (wr_addr),
      .sel  (load_sel)
   );

   for (genvar i = 0; i < DEPTH; i++) begin : g_entry
      rf_word #(.DATA_W(DATA_W), .HARDWIRED(i == 0)) u_word (
         .clk  (clk),
         .load (load_sel[i]),
         .d    (wr_data),
         .q    (words[i])
      );
   end

   rf_rd_mux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd_a (
      .words (words),
      .addr  (rd_addr_a),
      .data  (rd_data_a)
   );

   rf_rd_mux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd_b (
      .words (words),
      .addr  (rd_addr_b),
      .data  (rd_data_b)
   );
endmodule

// File: rtl/rf_checker.sv
`timescale 1ns/1ps
module rf_checker #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 5
) (
   input logic              clk,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic [ADDR_W-1:0] rd_addr_a,
   input logic [DATA_W-1:0] rd_data_a,
   input logic [ADDR_W-1:0] rd_addr_b,
   input logic [DATA_W-1:0] rd_data_b
);
   // no reset exists, so checks start only once one edge has been seen
   logic primed = 1'b0;
   always_ff @(posedge clk) primed <= 1'b1;

   p_zero_a_r4: assert property (@(posedge clk) disable iff (!primed)
      (rd_addr_a == '0) |-> (rd_data_a == '0));

   p_zero_b_r4: assert property (@(posedge clk) disable iff (!primed)
      (rd_addr_b == '0) |-> (rd_data_b == '0));

   p_wr_lands_r2: assert property (@(posedge clk) disable iff (!primed)
      (wr_en && wr_addr != '0) |=>
         (rd_addr_a != $past(wr_addr) || rd_data_a == $past(wr_data)));

   p_hold_idle_r3: assert property (@(posedge clk) disable iff (!primed)
      (!wr_en) |=> (!$stable(rd_addr_a) || $stable(rd_data_a)));

   p_others_hold_r5: assert property (@(posedge clk) disable iff (!primed)
      (wr_en && wr_addr != rd_addr_b) |=>
         (!$stable(rd_addr_b) || $stable(rd_data_b)));

   p_same_addr_r8: assert property (@(posedge clk) disable iff (!primed)
      (rd_addr_a == rd_addr_b) |-> (rd_data_a == rd_data_b));
endmodule

bind dual_port_regfile rf_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rf_checker (
   .clk       (clk),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .wr_data   (wr_data),
   .rd_addr_a (rd_addr_a),
   .rd_data_a (rd_data_a),
   .rd_addr_b (rd_addr_b),
   .rd_data_b (rd_data_b)
);

// File: tb/dual_port_regfile_tb_top.sv
`timescale 1ns/1ps
module dual_port_regfile_tb_top;
   logic        clk = 1'b0;
   logic        wr_en = 1'b0;
   logic [4:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [4:0]  rd_addr_a = '0;
   logic [4:0]  rd_addr_b = '0;
   logic [31:0] rd_data_a;
   logic [31:0] rd_data_b;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   logic [31:0] model [32];

   always #2.5 clk = ~clk;

   dual_port_regfile dut_i (
      .clk       (clk),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .rd_addr_a (rd_addr_a),
      .rd_data_a (rd_data_a),
      .rd_addr_b (rd_addr_b),
      .rd_data_b (rd_data_b)
   );

   typedef struct packed {
      logic        en;
      logic [4:0]  wa;
      logic [31:0] wd;
      logic [4:0]  ra;
      logic [4:0]  rb;
   } row_t;

   localparam int NROWS = 12;
   localparam row_t ROWS [NROWS] = '{
      '{1'b1, 5'd3,  32'hDEADBEEF, 5'd3,  5'd3 },
      '{1'b0, 5'd5,  32'h12345678, 5'd5,  5'd5 },
      '{1'b1, 5'd0,  32'hFFFFFFFF, 5'd0,  5'd0 },
      '{1'b1, 5'd14, 32'h0BADF00D, 5'd14, 5'd13},
      '{1'b1, 5'd31, 32'h80000001, 5'd30, 5'd31},
      '{1'b0, 5'd31, 32'h00000000, 5'd31, 5'd31},
      '{1'b1, 5'd1,  32'h00000000, 5'd1,  5'd2 },
      '{1'b1, 5'd2,  32'hAAAA5555, 5'd2,  5'd1 },
      '{1'b0, 5'd0,  32'h5A5A5A5A, 5'd0,  5'd14},
      '{1'b1, 5'd16, 32'h7FFFFFFF, 5'd15, 5'd16},
      '{1'b1, 5'd16, 32'h13579BDF, 5'd16, 5'd16},
      '{1'b0, 5'd1,  32'hFFFF0000, 5'd3,  5'd14}
   };

   function automatic logic [31:0] pattern(input int i);
      logic [7:0] b;
      b = 8'(i);
      return {b, ~b, b ^ 8'h5A, 8'h3C};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic do_write(input logic en, input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = en; wr_addr = a; wr_data = d;
      @(posedge clk);
      if (en && a != 5'd0) model[a] = d;
      #1;
      wr_en = 1'b0;
   endtask

   task automatic sweep(input string req);
      for (int i = 0; i < 32; i++) begin
         @(negedge clk);
         rd_addr_a = 5'(i);
         rd_addr_b = 5'(31 - i);
         #1;
         chk(req, rd_data_a, model[i]);
         chk(req, rd_data_b, model[31 - i]);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      model[0] = '0;
      @(negedge clk);
      #1;
      // R4: entry 0 reads zero from the very start, on both ports
      chk("R4", rd_data_a, 32'h0);
      chk("R4", rd_data_b, 32'h0);

      // R1: fill entries 1..31 with distinct patterns
      for (int i = 1; i < 32; i++) do_write(1'b1, 5'(i), pattern(i));
      // R4: write to entry 0 must be discarded
      do_write(1'b1, 5'd0, 32'hFFFFFFFF);
      sweep("R1");

      // R3: disabled write everywhere leaves all entries intact
      for (int i = 0; i < 32; i++) do_write(1'b0, 5'(i), 32'hCAFEF00D);
      sweep("R3");

      // table of mixed operations
      for (int r = 0; r < NROWS; r++) begin
         string pre_tag;
         string post_tag;
         @(negedge clk);
         wr_en = ROWS[r].en; wr_addr = ROWS[r].wa; wr_data = ROWS[r].wd;
         rd_addr_a = ROWS[r].ra; rd_addr_b = ROWS[r].rb;
         #1;
         pre_tag = (ROWS[r].en && ROWS[r].ra == ROWS[r].wa) ? "R7" : "R6";
         chk(pre_tag, rd_data_a, model[ROWS[r].ra]);
         chk((ROWS[r].ra == ROWS[r].rb) ? "R8" : "R6", rd_data_b, model[ROWS[r].rb]);
         @(posedge clk);
         if (ROWS[r].en && ROWS[r].wa != 5'd0) model[ROWS[r].wa] = ROWS[r].wd;
         #1;
         wr_en = 1'b0;
         post_tag = !ROWS[r].en ? "R3" : (ROWS[r].wa == 5'd0) ? "R4" : "R2";
         chk((ROWS[r].ra == ROWS[r].wa) ? post_tag : "R5", rd_data_a, model[ROWS[r].ra]);
         chk((ROWS[r].rb == ROWS[r].wa) ? post_tag : "R5", rd_data_b, model[ROWS[r].rb]);
      end

      // R5: no spill-over anywhere after the table
      sweep("R5");

      // R6: address change within one clock phase updates the output at once
      @(posedge clk);
      #0.5;
      rd_addr_a = 5'd7; rd_addr_b = 5'd14;
      #0.5;
      chk("R6", rd_data_a, model[7]);
      chk("R6", rd_data_b, model[14]);
      rd_addr_a = 5'd14; rd_addr_b = 5'd7;
      #0.5;
      chk("R6", rd_data_a, model[14]);
      chk("R6", rd_data_b, model[7]);

      // R8: both ports on the same entry, several entries
      for (int i = 0; i < 32; i += 5) begin
         @(negedge clk);
         rd_addr_a = 5'(i); rd_addr_b = 5'(i);
         #1;
         chk("R8", rd_data_a, model[i]);
         chk("R8", rd_data_b, model[i]);
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule